// File: doc/BRIEF.md
# Fractional Tick Forwarding Accumulator

This block takes a fast periodic tick, typically from a timer channel that has been sped up, and works out which of those ticks should also be passed on to a slower legacy consumer. The legacy consumer expects ticks at an average rate equal to the input clock frequency divided by 65536. On every fast tick the block adds a programmed reload value to a running remainder. If the sum reaches 65536 or more, the block takes 65536 off the sum and raises a forward pulse. Otherwise it raises a local-acknowledge pulse.

Because the remainder left after each subtraction is kept, no fraction of a period is lost. The long-term forward rate is therefore exact for any reload value, and does not drift the way a plain divider would. For example, a 100 Hz fast tick taken from a 1193181 Hz clock uses a reload of 11931. A reload of zero stands for 65536, so every tick is forwarded in that case.

Top module: `tick_forwarder`

## Requirements
- R1: After reset both outputs are low and the remainder is zero. With a reload of 0x8000, the first tick after reset is acknowledged locally.
- R2: Each fast tick adds the current effective reload value to the remainder.
- R3: When the sum is at least 0x10000, 0x10000 is subtracted and `fwd_o` pulses. A sum of exactly 0x10000 forwards and leaves a remainder of zero.
- R4: A tick whose sum stays below 0x10000 pulses `ack_o` and does not pulse `fwd_o`.
- R5: For each tick, exactly one of `fwd_o` and `ack_o` is high, for one cycle, in the cycle after the tick is sampled. This holds for ticks on consecutive cycles too.
- R6: A reload value of 0 acts as 65536, so every tick is forwarded.
- R7: A new reload value is used from the next tick onward, and the remainder built up so far is not cleared.
- R8: In a cycle without a tick, both outputs are low and the remainder is unchanged.
- R9: Over N ticks at a constant reload value V, the number of forwards is floor(N·V/65536).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Fast tick, one cycle high per tick |
| reload_i | input | CNT_W (16) | Per-tick increment; 0 stands for 2^CNT_W |
| fwd_o | output | 1 | One-cycle pulse: tick is passed on to the legacy path |
| ack_o | output | 1 | One-cycle pulse: tick is handled locally |

## Verification
The bench builds the block with its default CNT_W of 16, so the threshold is the real 65536 boundary. With that width, a pair of 0x8000 reloads lands exactly on the threshold, and a reload of 0xFFFF leaves remainders just below it. The run with 11931 over 1000 ticks checks the long-term forward count against 182. The bench's behavioural model is compared on every clock, including runs of back-to-back ticks and reload changes made mid-stream.

// File: rtl/tick_fwd_pkg.sv
package tick_fwd_pkg;
  // Outcome of one clock cycle at the accumulator.
  typedef enum logic [1:0] {
    EV_IDLE    = 2'd0,
    EV_LOCAL   = 2'd1,
    EV_FORWARD = 2'd2
  } tick_ev_e;
endpackage

// File: rtl/tick_fwd_reload.sv
module tick_fwd_reload #(
  parameter int CNT_W = 16,
  localparam int EFF_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] reload_i,
  output logic [EFF_W-1:0] eff_o
);
  // A zero reload stands for the full 2^CNT_W period.
  function automatic logic [EFF_W-1:0] expand(input logic [CNT_W-1:0] r);
    if (r == '0) return {1'b1, {CNT_W{1'b0}}};
    return {1'b0, r};
  endfunction

  assign eff_o = expand(reload_i);
endmodule

// File: rtl/tick_fwd_core.sv
module tick_fwd_core
  import tick_fwd_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int EFF_W = CNT_W + 1,
  localparam int ACC_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [EFF_W-1:0] eff_i,
  output tick_ev_e         ev_o
);
  localparam logic [ACC_W-1:0] THRESH = {2'b01, {CNT_W{1'b0}}};

  logic [ACC_W-1:0] rem_q;
  logic [ACC_W-1:0] sum_w;
  logic [ACC_W-1:0] next_rem_w;
  logic             cross_w;

  function automatic logic [ACC_W-1:0] add_eff(input logic [ACC_W-1:0] rem,
                                               input logic [EFF_W-1:0] eff);
    return rem + {1'b0, eff};
  endfunction

  function automatic logic [ACC_W-1:0] wrap(input logic [ACC_W-1:0] s);
    return (s >= THRESH) ? s - THRESH : s;
  endfunction

  assign sum_w      = add_eff(rem_q, eff_i);
  assign cross_w    = (sum_w >= THRESH);
  assign next_rem_w = wrap(sum_w);

  always_comb begin
    if (!tick_i)      ev_o = EV_IDLE;
    else if (cross_w) ev_o = EV_FORWARD;
    else              ev_o = EV_LOCAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (tick_i) rem_q <= next_rem_w;
  end

  // R3: remainder kept strictly below the threshold
  p_rem_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q < THRESH);
  // R8: no tick leaves the remainder alone
  p_rem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(rem_q));
  // R2: a tick that stays local grows the remainder by the reload
  p_local_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && ev_o == EV_LOCAL) |=> (rem_q > $past(rem_q)));
endmodule

// File: rtl/tick_fwd_pulse.sv
module tick_fwd_pulse
  import tick_fwd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  tick_ev_e ev_i,
  output logic     fwd_o,
  output logic     ack_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_o <= 1'b0;
      ack_o <= 1'b0;
    end else begin
      fwd_o <= (ev_i == EV_FORWARD);
      ack_o <= (ev_i == EV_LOCAL);
    end
  end

  // R5: never both outputs at once
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_o, ack_o}));
endmodule

// File: rtl/tick_forwarder.sv
module tick_forwarder
  import tick_fwd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             fwd_o,
  output logic             ack_o
);
  localparam int EFF_W = CNT_W + 1;

  logic [EFF_W-1:0] eff_w;
  tick_ev_e         ev_w;

  tick_fwd_reload #(.CNT_W(CNT_W)) u_reload (
    .reload_i (reload_i),
    .eff_o    (eff_w)
  );

  tick_fwd_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .eff_i  (eff_w),
    .ev_o   (ev_w)
  );

  tick_fwd_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_i  (ev_w),
    .fwd_o (fwd_o),
    .ack_o (ack_o)
  );

  // R5: every tick yields a pulse on the next cycle
  p_tick_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (fwd_o || ack_o));
  // R8: quiet cycle gives quiet outputs
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> (!fwd_o && !ack_o));
  // R6: zero reload always forwards
  p_zero_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && reload_i == '0) |=> fwd_o);
endmodule

// File: tb/tick_forwarder_test.sv
module tick_forwarder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [15:0] reload_i = '0;
  logic        fwd_o, ack_o;

  int compared = 0;
  int mismatched = 0;
  int rem = 0;
  logic exp_fwd = 1'b0, exp_ack = 1'b0;
  string req = "R1";
  int fwd_seen = 0;

  tick_forwarder uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(reload_i),
    .fwd_o(fwd_o), .ack_o(ack_o)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // One clock: check outputs from the previous cycle, then apply new inputs.
  task automatic cyc(input logic t, input int r);
    @(negedge clk);
    compared++;
    if (fwd_o !== exp_fwd || ack_o !== exp_ack) begin
      mismatched++;
      $display("FAIL %s: fwd/ack=%b%b expected %b%b", req, fwd_o, ack_o, exp_fwd, exp_ack);
    end
    if (fwd_o === 1'b1) fwd_seen++;
    exp_fwd = 1'b0;
    exp_ack = 1'b0;
    if (rst_n && t) begin
      rem += (r == 0) ? 65536 : r;
      if (rem >= 65536) begin
        rem -= 65536;
        exp_fwd = 1'b1;
      end else begin
        exp_ack = 1'b1;
      end
    end
    tick_i = t;
    reload_i = r[15:0];
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rem = 0;
    for (int i = 0; i < 3; i++) cyc(1'b0, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, then first tick from zero remainder is local
    req = "R1";
    do_reset();
    cyc(1'b1, 16'h8000);
    // R3: exact threshold forwards, remainder back to zero
    req = "R3";
    cyc(1'b1, 16'h8000);
    // R8: idle cycles hold remainder
    req = "R8";
    cyc(1'b1, 16'h8000);
    for (int i = 0; i < 5; i++) cyc(1'b0, 16'h1234);
    cyc(1'b1, 16'h8000);
    cyc(1'b0, 0);
    // R2 / R4: small reload accumulates locally
    req = "R4";
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1000);
      cyc(1'b0, 1000);
    end
    // R2: many small ticks eventually cross
    req = "R2";
    for (int i = 0; i < 70; i++) cyc(1'b1, 1000);
    // R5: back-to-back ticks with large reload
    req = "R5";
    for (int i = 0; i < 20; i++) cyc(1'b1, 16'hFFFF);
    // R6: zero reload forwards every tick
    req = "R6";
    for (int i = 0; i < 8; i++) cyc(1'b1, 0);
    cyc(1'b0, 0);
    // R7: reload change keeps remainder
    req = "R7";
    cyc(1'b1, 16'h6000);
    cyc(1'b1, 16'h6000);
    cyc(1'b1, 16'h5000);
    cyc(1'b1, 16'h0100);
    cyc(1'b1, 16'h3F00);
    cyc(1'b1, 16'h9000);
    cyc(1'b0, 0);
    // R9: long-run forward count
    req = "R9";
    do_reset();
    fwd_seen = 0;
    for (int i = 0; i < 1000; i++) begin
      cyc(1'b1, 11931);
      cyc(1'b0, 11931);
    end
    cyc(1'b0, 0);
    compared++;
    if (fwd_seen != 182) begin
      mismatched++;
      $display("FAIL R9: forwards=%0d expected %0d", fwd_seen, 182);
    end
    summary();
    $finish;
  end
endmodule